// File: doc/BRIEF.md
# Doubleword Load/Store Beat Sequencer

This block carries out 64-bit store-doubleword and load-doubleword instructions for a core whose data memory port is only 32 bits wide. When the core presents one of these instructions, the block computes the effective address, which is the base register plus the sign-extended 16-bit offset. It then checks that the address is 8-byte aligned. An aligned access is split into two consecutive 32-bit beats. A misaligned one raises the store or load address-error indication instead, and no memory or register write takes place.

The core keeps only the low 32 bits of each register. A store therefore writes the low word of rt at the effective address and zero at the effective address plus 4. A load reads both words, keeps the low word and discards the high word. It writes rt exactly once, in the cycle the instruction retires. While the beats are in flight the block holds the core from retiring. Each beat waits for the memory acknowledge before it advances.

The controller has four states:
- IDLE waits for an instruction.
- BEAT issues the memory requests, with a beat counter selecting word 0 or word 1.
- FAULT raises the address error for one cycle.
- RETIRE pulses retirement for one cycle.

The transitions are:
- start-aligned: IDLE to BEAT.
- start-misaligned: IDLE to FAULT.
- beat-advance: BEAT to BEAT, on the acknowledge of beat 0.
- last-beat: BEAT to RETIRE, on the acknowledge of beat 1.
- fault-return: FAULT to IDLE.
- retire-return: RETIRE to IDLE.

The beat counter returns to 0 on completion and on an address error.

Top module: `dword_seq`

## Requirements
- R1: The opcode is instr[31:26]. 6'h3F is store doubleword and 6'h37 is load doubleword. The base register is instr[25:21], rt is instr[20:16] and the offset is instr[15:0]. rs_sel and rt_sel always show those two register fields. An issued instruction with any other opcode is ignored: no hold, request, fault or retire follows.
- R2: The effective address is rs_data plus the sign-extended offset. The word 32'hFFBF0020 decodes as a store of register 31 at offset 0x20 from register 29.
- R3: A store whose effective address has a non-zero value in bits [2:0] goes from IDLE to FAULT. There, store_fault is 1 for exactly one cycle, with fault_addr equal to the effective address, and no memory request is made.
- R4: A misaligned load raises load_fault for one cycle in the same way. It makes no memory request and no register write.
- R5: An aligned store makes two write beats. Beat 0 writes rt_data low word (latched at issue) to the effective address. Beat 1 writes zero to the effective address plus 4.
- R6: An aligned load makes two read beats, at the effective address and the effective address plus 4. It then writes the beat-0 word into rt once, in the RETIRE cycle. The beat-1 word is discarded.
- R7: A beat advances only in a cycle where mem_req and mem_ack are both 1. While it waits, the request, address, write enable and write data stay stable.
- R8: hold is 1 from the cycle the instruction is accepted until the final beat is acknowledged. retire is a single-cycle pulse one cycle after that acknowledge, and rf_we is 1 only in that cycle.
- R9: An instruction presented while the block is not in IDLE is ignored.
- R10: After reset the block is in IDLE, with mem_req, hold, retire, rf_we and both fault outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rs_data | input | 32 | Value of the base register selected by rs_sel |
| rt_data | input | 32 | Value of the register selected by rt_sel |
| rs_sel | output | 5 | Base register index decoded from instr |
| rt_sel | output | 5 | Data register index decoded from instr |
| hold | output | 1 | Stall the core's retirement |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Beat write data |
| mem_rdata | input | 32 | Beat read data |
| mem_ack | input | 1 | Memory accepts the current beat |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| retire | output | 1 | Instruction retires this cycle |
| store_fault | output | 1 | Store address error |
| load_fault | output | 1 | Load address error |
| fault_addr | output | 32 | Faulting effective address |

## Verification
A wrong beat count or a corrupted latched address shows up at mem_addr or mem_wdata in the very cycle of the affected beat. A state stuck in BEAT shows as hold staying high with no retire pulse. A lost load capture appears as a wrong rf_wdata in the RETIRE cycle, two or more cycles after the first beat. The bench predicts every output on every clock, so any such divergence is reported in the cycle it first appears.

// File: rtl/dword_seq_pkg.sv
package dword_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BEAT   = 2'd1,
        ST_FAULT  = 2'd2,
        ST_RETIRE = 2'd3
    } seq_state_t;

    localparam logic [5:0] OPC_STORE_DW = 6'h3F;
    localparam logic [5:0] OPC_LOAD_DW  = 6'h37;

    typedef struct packed {
        logic        is_store;
        logic        is_load;
        logic [4:0]  base_idx;
        logic [4:0]  data_idx;
        logic [15:0] offset;
    } dw_fields_t;
endpackage

// File: rtl/dword_decode.sv
module dword_decode
    import dword_seq_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 3
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] base_val,
    output dw_fields_t      fields,
    output logic [XLEN-1:0] eff_addr,
    output logic            misaligned
);
    logic [XLEN-1:0] offset_ext;

    always_comb begin
        fields.is_store = (instr[31:26] == OPC_STORE_DW);
        fields.is_load  = (instr[31:26] == OPC_LOAD_DW);
        fields.base_idx = instr[25:21];
        fields.data_idx = instr[20:16];
        fields.offset   = instr[15:0];
        offset_ext      = {{(XLEN-16){instr[15]}}, instr[15:0]};
        eff_addr        = base_val + offset_ext;
        misaligned      = |eff_addr[ALIGN_BITS-1:0];
    end
endmodule

// File: rtl/dword_fsm.sv
module dword_fsm
    import dword_seq_pkg::*;
#(
    parameter int NBEATS = 2,
    localparam int CNT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_bad,
    input  logic             beat_ack,
    output seq_state_t       state,
    output logic [CNT_W-1:0] beat_idx
);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(NBEATS - 1);

    seq_state_t       state_nx;
    logic [CNT_W-1:0] cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat_idx <= '0;
        end else begin
            state    <= state_nx;
            beat_idx <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = beat_idx;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (start) begin
                    state_nx = start_bad ? ST_FAULT : ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (beat_ack) begin
                    if (beat_idx == LAST_BEAT) begin
                        state_nx = ST_RETIRE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = beat_idx + 1'b1;
                    end
                end
            end
            ST_FAULT: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
            ST_RETIRE: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end
endmodule

// File: rtl/dword_datapath.sv
module dword_datapath #(
    parameter int XLEN   = 32,
    parameter int NBEATS = 2,
    localparam int CNT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1,
    localparam int OFF_SH = $clog2(XLEN / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [XLEN-1:0]  eff_addr,
    input  logic [4:0]       data_idx,
    input  logic [XLEN-1:0]  store_word,
    input  logic             is_load,
    input  logic             lo_ack,
    input  logic [XLEN-1:0]  rd_word,
    input  logic [CNT_W-1:0] beat_idx,
    output logic [XLEN-1:0]  ea_q,
    output logic [4:0]       rt_q,
    output logic             load_q,
    output logic [XLEN-1:0]  lo_word_q,
    output logic [XLEN-1:0]  beat_addr,
    output logic [XLEN-1:0]  beat_wdata
);
    logic [XLEN-1:0] st_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q      <= '0;
            rt_q      <= '0;
            load_q    <= 1'b0;
            st_lo_q   <= '0;
            lo_word_q <= '0;
        end else begin
            if (capture) begin
                ea_q    <= eff_addr;
                rt_q    <= data_idx;
                load_q  <= is_load;
                st_lo_q <= store_word;
            end
            if (lo_ack && load_q) begin
                lo_word_q <= rd_word;
            end
        end
    end

    always_comb begin
        beat_addr  = ea_q + (XLEN'(beat_idx) << OFF_SH);
        beat_wdata = (beat_idx == '0) ? st_lo_q : '0;
    end
endmodule

// File: rtl/dword_seq.sv
module dword_seq
    import dword_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NBEATS = 2,
    localparam int CNT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1,
    localparam int ALIGN_BITS = $clog2(NBEATS * (XLEN / 8))
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_data,
    input  logic [XLEN-1:0] rt_data,
    output logic [4:0]      rs_sel,
    output logic [4:0]      rt_sel,
    output logic            hold,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ack,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            retire,
    output logic            store_fault,
    output logic            load_fault,
    output logic [XLEN-1:0] fault_addr
);
    dw_fields_t       fields;
    logic [XLEN-1:0]  eff_addr;
    logic             misaligned;
    seq_state_t       state;
    logic [CNT_W-1:0] beat_idx;
    logic             start;
    logic             beat_ack;
    logic             lo_ack;
    logic [XLEN-1:0]  ea_q;
    logic [4:0]       rt_q;
    logic             load_q;
    logic [XLEN-1:0]  lo_word_q;
    logic [XLEN-1:0]  beat_addr;
    logic [XLEN-1:0]  beat_wdata;

    dword_decode #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_decode (
        .instr      (instr),
        .base_val   (rs_data),
        .fields     (fields),
        .eff_addr   (eff_addr),
        .misaligned (misaligned)
    );

    assign start    = issue_valid && (state == ST_IDLE) && (fields.is_store || fields.is_load);
    assign beat_ack = (state == ST_BEAT) && mem_ack;
    assign lo_ack   = beat_ack && (beat_idx == '0);

    dword_fsm #(.NBEATS(NBEATS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_bad (misaligned),
        .beat_ack  (beat_ack),
        .state     (state),
        .beat_idx  (beat_idx)
    );

    dword_datapath #(.XLEN(XLEN), .NBEATS(NBEATS)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (start),
        .eff_addr   (eff_addr),
        .data_idx   (fields.data_idx),
        .store_word (rt_data),
        .is_load    (fields.is_load),
        .lo_ack     (lo_ack),
        .rd_word    (mem_rdata),
        .beat_idx   (beat_idx),
        .ea_q       (ea_q),
        .rt_q       (rt_q),
        .load_q     (load_q),
        .lo_word_q  (lo_word_q),
        .beat_addr  (beat_addr),
        .beat_wdata (beat_wdata)
    );

    always_comb begin
        rs_sel      = fields.base_idx;
        rt_sel      = fields.data_idx;
        hold        = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        rf_we       = 1'b0;
        rf_waddr    = rt_q;
        rf_wdata    = lo_word_q;
        retire      = 1'b0;
        store_fault = 1'b0;
        load_fault  = 1'b0;
        fault_addr  = ea_q;
        unique case (state)
            ST_IDLE: begin
                hold = start;
            end
            ST_BEAT: begin
                hold      = 1'b1;
                mem_req   = 1'b1;
                mem_we    = !load_q;
                mem_addr  = beat_addr;
                mem_wdata = load_q ? '0 : beat_wdata;
            end
            ST_FAULT: begin
                store_fault = !load_q;
                load_fault  = load_q;
            end
            ST_RETIRE: begin
                retire = 1'b1;
                rf_we  = load_q;
            end
            default: begin
                hold = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dword_seq_checker.sv
module dword_seq_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ack,
    input logic            rf_we,
    input logic            retire,
    input logic            store_fault,
    input logic            load_fault
);
    AST_REQ_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> hold); // R8

    AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (store_fault || load_fault) |-> (!mem_req && !rf_we && !retire)); // R3

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_fault && load_fault)); // R4

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R7

    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire); // R8

    AST_RFWE_AT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> retire); // R6

    AST_HIGH_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr[2]) |-> (mem_wdata == '0)); // R5
endmodule

bind dword_seq dword_seq_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold        (hold),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .rf_we       (rf_we),
    .retire      (retire),
    .store_fault (store_fault),
    .load_fault  (load_fault)
);

// File: tb/dword_seq_tb.sv
module dword_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_data = '0;
    logic [31:0] rt_data = '0;
    logic [4:0]  rs_sel, rt_sel, rf_waddr;
    logic        hold, mem_req, mem_we, mem_ack, rf_we, retire;
    logic        store_fault, load_fault;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, fault_addr;

    logic [31:0] bench_mem [0:63];
    assign mem_rdata = bench_mem[mem_addr[7:2]];

    always #4 clk = ~clk;

    dword_seq u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
        .rs_data(rs_data), .rt_data(rt_data), .rs_sel(rs_sel), .rt_sel(rt_sel),
        .hold(hold), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .retire(retire),
        .store_fault(store_fault), .load_fault(load_fault), .fault_addr(fault_addr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference: 0 idle, 1 beat, 2 fault, 3 retire
    int          m_st = 0;
    int          m_cnt = 0;
    logic [31:0] m_ea = '0;
    logic        m_ld = 1'b0;
    logic [4:0]  m_rt = '0;
    logic [31:0] m_lo = '0;
    logic [31:0] m_cap = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_dw(input logic [31:0] w);
        return (w[31:26] == 6'h3F) || (w[31:26] == 6'h37);
    endfunction

    task automatic tick();
        logic [31:0] ea;
        logic [31:0] exp_addr;
        logic [31:0] exp_wd;
        bit          acc;
        #1;
        acc = rst_n && issue_valid && (m_st == 0) && is_dw(instr);
        chk(rs_sel == instr[25:21], "R1 rs_sel", 32'(rs_sel), 32'(instr[25:21]));
        chk(rt_sel == instr[20:16], "R1 rt_sel", 32'(rt_sel), 32'(instr[20:16]));
        chk(hold == (acc || m_st == 1), "R8 hold", 32'(hold), 32'(acc || m_st == 1));
        chk(mem_req == (m_st == 1), "R7 mem_req", 32'(mem_req), 32'(m_st == 1));
        chk(retire == (m_st == 3), "R8 retire", 32'(retire), 32'(m_st == 3));
        chk(rf_we == (m_st == 3 && m_ld), "R6 rf_we", 32'(rf_we), 32'(m_st == 3 && m_ld));
        chk(store_fault == (m_st == 2 && !m_ld), "R3 store_fault", 32'(store_fault), 32'(m_st == 2 && !m_ld));
        chk(load_fault == (m_st == 2 && m_ld), "R4 load_fault", 32'(load_fault), 32'(m_st == 2 && m_ld));
        exp_addr = m_ea + 32'(m_cnt * 4);
        exp_wd   = (m_cnt == 0) ? m_lo : 32'h0;
        if (m_st == 1) begin
            chk(mem_addr == exp_addr, m_ld ? "R6 read addr" : "R5 write addr", mem_addr, exp_addr);
            chk(mem_we == !m_ld, "R6 mem_we", 32'(mem_we), 32'(!m_ld));
            if (!m_ld) chk(mem_wdata == exp_wd, "R5 write data", mem_wdata, exp_wd);
        end
        if (m_st == 2) chk(fault_addr == m_ea, "R2 fault_addr", fault_addr, m_ea);
        if (m_st == 3 && m_ld) begin
            chk(rf_waddr == m_rt, "R6 rf_waddr", 32'(rf_waddr), 32'(m_rt));
            chk(rf_wdata == m_cap, "R6 rf_wdata", rf_wdata, m_cap);
        end
        // advance model
        if (!rst_n) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (acc) begin
                    ea   = rs_data + {{16{instr[15]}}, instr[15:0]};
                    m_ea = ea; m_ld = (instr[31:26] == 6'h37);
                    m_rt = instr[20:16]; m_lo = rt_data;
                    m_st = (ea[2:0] != 3'b0) ? 2 : 1; m_cnt = 0;
                end
                1: if (mem_ack) begin
                    if (!m_ld) bench_mem[exp_addr[7:2]] = exp_wd;
                    else if (m_cnt == 0) m_cap = bench_mem[exp_addr[7:2]];
                    if (m_cnt == 1) begin m_st = 3; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
                default: begin m_st = 0; m_cnt = 0; end
            endcase
        end
        @(negedge clk);
    endtask

    // issue one instruction and run it to completion; waits = idle ack cycles per beat
    task automatic run_instr(input logic [31:0] w, input logic [31:0] rs, input logic [31:0] rt,
                             input int waits, input bit noise);
        int wc = 0;
        issue_valid = 1'b1; instr = w; rs_data = rs; rt_data = rt; mem_ack = 1'b0;
        tick();
        while (m_st != 0) begin
            // R9: a second instruction presented while busy must be ignored
            issue_valid = noise; instr = 32'hFC0A0008; rs_data = 32'h0; rt_data = 32'hDEADBEEF;
            if (m_st == 1) begin
                mem_ack = (wc == waits);
                wc = (wc == waits) ? 0 : wc + 1;
            end else mem_ack = 1'b0;
            tick();
        end
        issue_valid = 1'b0; mem_ack = 1'b0; instr = 32'h0;
        tick();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bench_mem[i] = 32'hA5A50000 | 32'(i);
        mem_ack = 1'b0;
        @(negedge clk);
        // R10 reset state
        repeat (3) tick();
        chk(!hold && !mem_req && !retire && !store_fault && !load_fault, "R10 reset idle",
            {hold, mem_req, retire, store_fault, load_fault}, 32'h0);
        rst_n = 1'b1;
        tick();
        // R2: 0xFFBF0020 decodes as store of r31 at 0x20 from r29
        instr = 32'hFFBF0020; #1;
        chk(rs_sel == 5'd29 && rt_sel == 5'd31, "R2 decode FFBF0020", {rs_sel, rt_sel}, {5'd29, 5'd31});
        // R5 store, immediate ack
        run_instr(32'hFFBF0020, 32'h40, 32'h12345678, 0, 1'b0);
        chk(bench_mem[24] == 32'h12345678 && bench_mem[25] == 32'h0, "R5 stored words",
            bench_mem[25], 32'h0);
        // R6 load back
        run_instr(32'hDFBF0020, 32'h40, 32'h0, 0, 1'b0);
        // R7 store with wait states, negative offset, busy noise
        run_instr(32'hFC45FFF8, 32'h80, 32'hCAFEF00D, 2, 1'b1);
        chk(bench_mem[30] == 32'hCAFEF00D, "R7 stored after waits", bench_mem[30], 32'hCAFEF00D);
        // R6 load with waits and noise
        run_instr(32'hDC46FFF8, 32'h80, 32'h0, 1, 1'b1);
        // R3 misaligned store
        run_instr(32'hFC470004, 32'h10, 32'h99999999, 0, 1'b0);
        chk(bench_mem[5] == 32'hA5A50005, "R3 no write on fault", bench_mem[5], 32'hA5A50005);
        // R4 misaligned load
        run_instr(32'hDC480001, 32'h20, 32'h0, 0, 1'b0);
        // R1 non-dword opcode ignored
        run_instr(32'hAC490000, 32'h20, 32'h77777777, 0, 1'b0);
        repeat (2) tick();
        // R6 final round trip from earlier slot with long waits
        run_instr(32'hDFA30020, 32'h40, 32'h0, 3, 1'b1);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule